// File: doc/BRIEF.md
# Watchdog Timer with Byte Self-Test

The block is a 16-bit watchdog counter with a programmable timeout. When the counter reaches the timeout, the block asks the system to reset. A two-bit test field selects how the count and compare logic runs. In the two test modes only one byte of the counter counts, and only that byte is compared with the matching byte of the timeout. This lets boot code check each half of the counter in a few hundred cycles instead of tens of thousands. The same field also marks the end of testing and the start of normal operation.

Software reaches the block through a small synchronous register bus with three registers: control/status, timeout and counter. A refresh strobe restarts the count. Two reset inputs are kept apart. Power-on reset clears everything. The ordinary system reset, which the system asserts after a watchdog request, clears only the counting state. The test field, the timeout value and the reset-cause flags survive it, so that after a reset software can tell which test ran and what caused the reset.

The timeout register can be written only during a short configuration window after each reset.

Top module: `wdt_bytecheck`

## Requirements
- R1: With test field 2'b10 (low-byte test), only counter bits 7:0 advance, one per clock, and bits 15:8 do not change. A timeout happens when bits 7:0 equal timeout bits 7:0. With the timeout low byte equal to N, the request pulse appears N+1 clock edges after reset is released.
- R2: With test field 2'b11 (high-byte test), counter bits 15:8 advance one per clock while bits 7:0 stay at zero. A timeout happens when bits 15:8 equal timeout bits 15:8. The pulse appears H+1 edges after reset release, where H is the timeout high byte.
- R3: With test field 2'b01 (user) or 2'b00, the whole 16-bit counter advances and is compared with the whole 16-bit timeout. The pulse appears T+1 edges after reset release.
- R4: The timeout register (address 1) accepts writes only during the first 128 clock edges after release of either reset. Writes after that are ignored.
- R5: The reset request `wdt_rst_o` is a pulse one cycle wide. After it, no further pulse appears until a refresh or a reset.
- R6: A refresh strobe clears the counter to zero at the next edge and restarts the timeout period.
- R7: Control register bit 9 is the power-on cause flag and bit 8 is the watchdog cause flag. Power-on reset sets bit 9 and clears bit 8. A timeout sets bit 8 and clears bit 9. A system reset leaves both flags unchanged.
- R8: The test field (control bits 1:0, read/write) is cleared only by power-on reset. A system reset leaves it unchanged.
- R9: The counter (address 2) can be read at any time and shows the running count. After power-on reset the timeout reads 16'hFFFF, the test field reads 2'b00 and the counter starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous; clears counting state only |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | 2 | Register address: 0 control, 1 timeout, 2 counter |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| refresh_i | input | 1 | Refresh strobe, clears the counter |
| wdt_rst_o | output | 1 | Reset request, one-cycle pulse |
| cause_wdt_o | output | 1 | Last reset came from the watchdog |
| cause_por_o | output | 1 | Last reset was power-on |

## Verification
The timeout latency is measured across all four codes of the test field, and the same timeout values are used in more than one mode. A timeout of 16'h0305, for example, must fire after 6 edges in low-byte mode, 4 in high-byte mode and 774 in user mode. Any mistake in which byte counts or which byte is compared therefore shows up as a wrong latency. Zero-byte timeouts and an all-ones low byte test the wrap and immediate-match edges. Blocked timeout writes, a refresh held off just short of the limit, and the survival of the flags and test field across a system reset are checked by reading the registers back.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_USER = 2'b01,
    MODE_LOW  = 2'b10,
    MODE_HIGH = 2'b11
  } wdt_mode_e;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_TOV  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd2;

  localparam int unsigned BIT_CAUSE_WDT = 8;
  localparam int unsigned BIT_CAUSE_POR = 9;
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   mode_i,
  input  logic [W-1:0] toval_i,
  input  logic         refresh_i,
  output logic [W-1:0] cnt_o,
  output logic         fire_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0]    cnt_q, cnt_d;
  logic [HALF-1:0] lo_q, hi_q, lo_inc, hi_inc;
  logic            fired_q, fire_q;
  logic            match, hit;

  assign lo_q   = cnt_q[HALF-1:0];
  assign hi_q   = cnt_q[W-1:HALF];
  assign lo_inc = lo_q + 1'b1;
  assign hi_inc = hi_q + 1'b1;

  always_comb begin
    unique case (mode_i)
      MODE_LOW:  match = (lo_q == toval_i[HALF-1:0]);
      MODE_HIGH: match = (hi_q == toval_i[W-1:HALF]);
      default:   match = (cnt_q == toval_i);
    endcase
  end

  // one request per period: fired_q blocks until refresh or reset
  assign hit = match && !fired_q && !refresh_i;

  always_comb begin
    if (refresh_i || hit) begin
      cnt_d = '0;
    end else if (fired_q) begin
      cnt_d = cnt_q;
    end else begin
      unique case (mode_i)
        MODE_LOW:  cnt_d = {hi_q, lo_inc};
        MODE_HIGH: cnt_d = {hi_inc, {HALF{1'b0}}};
        default:   cnt_d = cnt_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      fired_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fire_q  <= hit;
      fired_q <= refresh_i ? 1'b0 : (fired_q | hit);
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> !fire_o);

  a_r6_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (cnt_o == '0));

  a_r2_low_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_HIGH) |=> (cnt_o[HALF-1:0] == '0));

  a_r1_high_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LOW && !refresh_i && !match) |=> $stable(cnt_o[W-1:HALF]));
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk_i,
  input  logic por_ni,
  input  logic fire_i,
  output logic cause_wdt_o,
  output logic cause_por_o
);
  logic wdt_q, por_q;

  // only power-on clears this storage
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      wdt_q <= 1'b0;
      por_q <= 1'b1;
    end else if (fire_i) begin
      wdt_q <= 1'b1;
      por_q <= 1'b0;
    end
  end

  assign cause_wdt_o = wdt_q;
  assign cause_por_o = por_q;

  a_r7_cause_set: assert property (@(posedge clk_i) disable iff (!por_ni)
    fire_i |=> (cause_wdt_o && !cause_por_o));

  a_r7_exclusive: assert property (@(posedge clk_i) disable iff (!por_ni)
    !(cause_wdt_o && cause_por_o));
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned W          = CNT_W,
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned WIN_CYCLES = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  cnt_i,
  input  logic          cause_wdt_i,
  input  logic          cause_por_i,
  output logic [1:0]    mode_o,
  output logic [W-1:0]  toval_o
);
  localparam int unsigned WIN_W = $clog2(WIN_CYCLES + 1);
  localparam logic [WIN_W-1:0] WIN_END = WIN_W'(WIN_CYCLES);

  logic [WIN_W-1:0] win_q;
  logic             win_open;
  logic [W-1:0]     toval_q;
  logic [1:0]       test_q;
  logic             wr_ctrl, wr_tov;

  assign win_open = (win_q != WIN_END);
  assign wr_ctrl  = req_i && we_i && (addr_i == ADDR_CTRL);
  assign wr_tov   = req_i && we_i && (addr_i == ADDR_TOV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       win_q <= '0;
    else if (win_open) win_q <= win_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      toval_q <= '1;
      test_q  <= MODE_NONE;
    end else begin
      if (wr_tov && win_open && rst_ni) toval_q <= wdata_i;
      if (wr_ctrl && rst_ni)            test_q  <= wdata_i[1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[1:0]          = test_q;
        rdata_o[BIT_CAUSE_WDT] = cause_wdt_i;
        rdata_o[BIT_CAUSE_POR] = cause_por_i;
      end
      ADDR_TOV: rdata_o = toval_q;
      ADDR_CNT: rdata_o = cnt_i;
      default:  rdata_o = '0;
    endcase
  end

  assign mode_o  = test_q;
  assign toval_o = toval_q;

  a_r4_tov_locked: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_tov && !win_open) |=> $stable(toval_o));

  a_r8_test_kept: assert property (@(posedge clk_i) disable iff (!por_ni)
    !wr_ctrl |=> $stable(mode_o));
endmodule

// File: rtl/wdt_bytecheck.sv
module wdt_bytecheck
  import wdt_pkg::*;
#(
  parameter int unsigned W          = CNT_W,
  parameter int unsigned AW         = ADDR_W,
  parameter int unsigned WIN_CYCLES = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          por_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic          refresh_i,
  output logic          wdt_rst_o,
  output logic          cause_wdt_o,
  output logic          cause_por_o
);
  logic         run_rst_n;
  logic [1:0]   mode;
  logic [W-1:0] toval, cnt;
  logic         fire;

  // counting state clears on either reset
  assign run_rst_n = rst_ni & por_ni;

  wdt_regs #(.W(W), .AW(AW), .WIN_CYCLES(WIN_CYCLES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (run_rst_n),
    .por_ni      (por_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .cnt_i       (cnt),
    .cause_wdt_i (cause_wdt_o),
    .cause_por_i (cause_por_o),
    .mode_o      (mode),
    .toval_o     (toval)
  );

  wdt_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (run_rst_n),
    .mode_i    (mode),
    .toval_i   (toval),
    .refresh_i (refresh_i),
    .cnt_o     (cnt),
    .fire_o    (fire)
  );

  wdt_cause u_cause (
    .clk_i       (clk_i),
    .por_ni      (por_ni),
    .fire_i      (fire),
    .cause_wdt_o (cause_wdt_o),
    .cause_por_o (cause_por_o)
  );

  assign wdt_rst_o = fire;
endmodule

// File: tb/wdt_bytecheck_test.sv
module wdt_bytecheck_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1, por_ni = 1'b1;
  logic        req_i = 1'b0, we_i = 1'b0, refresh_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        wdt_rst_o, cause_wdt_o, cause_por_o;

  int checks = 0, fails = 0, cyc = 0;

  wdt_bytecheck uut (.*);

  always #4 clk_i = ~clk_i;

  // {mode, timeout, expected edges to pulse}
  localparam int NV = 9;
  localparam logic [33:0] VEC [NV] = '{
    {2'b10, 16'h0305, 16'd6},
    {2'b11, 16'h0305, 16'd4},
    {2'b01, 16'h0305, 16'd774},
    {2'b00, 16'h0105, 16'd262},
    {2'b10, 16'h4400, 16'd1},
    {2'b11, 16'h00FF, 16'd1},
    {2'b01, 16'h0000, 16'd1},
    {2'b10, 16'h00FF, 16'd256},
    {2'b11, 16'h0A00, 16'd11}
  };

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk_i); por_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    por_ni = 1'b1;
  endtask

  task automatic do_rst();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic edges_to_pulse(output int n);
    n = 0;
    while (n < 70000) begin
      @(negedge clk_i);
      n++;
      if (wdt_rst_o) break;
    end
  endtask

  initial begin
    logic [15:0] v, v2;
    int n;

    // reset state, R9 R7 R8
    do_por();
    rd(2'd0, v);
    chk("R7 por flags after power-on", {16'h0, v[9:8]}, 32'h2);
    chk("R8 test field after power-on", {30'h0, v[1:0]}, 32'h0);
    rd(2'd1, v);
    chk("R9 timeout default", v, 32'hFFFF);
    @(negedge clk_i); rd(2'd2, v);
    @(negedge clk_i); rd(2'd2, v2);
    chk("R9 counter advances", v2, v + 16'd1);

    // timeout latency table: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      do_rst();
      wr(2'd1, VEC[i][31:16]);
      wr(2'd0, {14'h0, VEC[i][33:32]});
      do_rst();
      edges_to_pulse(n);
      chk($sformatf("R1 R2 R3 latency vec %0d mode %b", i, VEC[i][33:32]), n, VEC[i][15:0]);
      @(negedge clk_i); rd(2'd0, v);
      chk("R7 watchdog cause after timeout", {16'h0, v[9:8]}, 32'h1);
    end

    // R5: no repeat pulse with zero low-byte match
    do_rst();
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0002);
    do_rst();
    edges_to_pulse(n);
    chk("R5 first pulse", n, 1);
    @(negedge clk_i);
    chk("R5 pulse one cycle wide", wdt_rst_o, 0);
    n = 0;
    repeat (300) begin
      @(negedge clk_i);
      if (wdt_rst_o) n++;
    end
    chk("R5 no further pulse", n, 0);

    // R1 high byte frozen in low-byte mode
    do_rst();
    wr(2'd1, 16'h00F0);
    wr(2'd0, 16'h0002);
    do_rst();
    repeat (100) @(negedge clk_i);
    rd(2'd2, v);
    chk("R1 low-byte mode keeps high byte", {16'h0, v[15:8]}, 32'h0);

    // R2 low byte zero in high-byte mode
    wr(2'd0, 16'h0003);
    repeat (5) @(negedge clk_i);
    rd(2'd2, v);
    chk("R2 high-byte mode low byte zero", {16'h0, v[7:0]}, 32'h0);

    // R6 refresh restarts and holds off timeout
    do_rst();
    wr(2'd1, 16'h0010);
    wr(2'd0, 16'h0002);
    do_rst();
    n = 0;
    for (int k = 0; k < 10; k++) begin
      repeat (14) begin
        @(negedge clk_i);
        if (wdt_rst_o) n++;
      end
      refresh_i = 1'b1;
      @(negedge clk_i);
      refresh_i = 1'b0;
      if (wdt_rst_o) n++;
      rd(2'd2, v);
      chk("R6 counter zero after refresh", v, 0);
    end
    chk("R6 no timeout while refreshed", n, 0);

    // R4 timeout write outside window
    do_rst();
    wr(2'd1, 16'h0ABC);
    rd(2'd1, v);
    chk("R4 write inside window", v, 32'h0ABC);
    repeat (130) @(negedge clk_i);
    wr(2'd1, 16'h1234);
    rd(2'd1, v);
    chk("R4 write outside window ignored", v, 32'h0ABC);

    // R8 R7 across system reset, then power-on
    wr(2'd0, 16'h0001);
    do_rst();
    rd(2'd0, v);
    chk("R8 test field kept over system reset", {30'h0, v[1:0]}, 32'h1);
    chk("R7 flags kept over system reset", {16'h0, v[9:8]}, 32'h1);
    rd(2'd1, v);
    chk("R4 timeout kept over system reset", v, 32'h0ABC);
    do_por();
    rd(2'd0, v);
    chk("R8 test field cleared by power-on", {30'h0, v[1:0]}, 32'h0);
    chk("R7 power-on cause", {16'h0, v[9:8]}, 32'h2);
    rd(2'd1, v);
    chk("R9 timeout restored by power-on", v, 32'hFFFF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule